// File: doc/BRIEF.md
# SDRAM Command Timing Monitor

This block watches the command pins of a four-bank SDRAM and never drives them. It samples the command lines at each rising clock edge. A command is taken only when chip select is low and clock enable is high. The block keeps the open or closed state of each bank, along with that bank's activate and precharge timers. It also tracks one auto-precharge burst at a time. Whenever a protocol or timing rule is broken, it sets a sticky error bit.

All timing limits are given in nanoseconds and converted to clock counts by rounding up against the clock period parameter. With the default 10 ns period this gives:

| Limit | Clock cycles |
|---|---|
| Activate to read or write | 2 |
| Precharge to activate | 2 |
| Minimum open time | 5 |
| Activate to activate, same bank | 7 |
| Activate to activate, other bank | 2 |
| Maximum open time | 10000 |

Software or a test harness reads two outputs: a flag vector with one bit per rule, and a code naming the earliest violation. A synchronous clear input empties both.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: A command is decoded only when cs_n is low and cke is high at the rising edge. A cycle with cs_n high or cke low sets no flag, whatever ras_n, cas_n and we_n hold. The command encodings on {ras_n,cas_n,we_n} are:
  - activate 011
  - read 101
  - write 100
  - precharge 010
  - refresh 001
  - mode set 000
  - burst stop 110
  - no-op 111
- R2: A read or write to a closed bank sets flag bit 0 (code 1).
- R3: A read or write less than 2 cycles after that bank's activate sets bit 1 (code 2). A gap of 2 or more is legal.
- R4: A precharge that closes a bank less than 5 cycles after its activate sets bit 2 (code 3). For an all-bank precharge, every open bank is checked.
- R5: An activate less than 2 cycles after that bank was closed sets bit 3 (code 4). The close may come from a precharge or from the end of an auto-precharge burst.
- R6: An activate less than 2 cycles after an activate to a different bank sets bit 4 (code 5). An activate less than 7 cycles after an activate to the same bank sets bit 5 (code 6).
- R7: A refresh or mode set while any bank is open sets bit 6 (code 7).
- R8: Any command other than no-op exactly 1 cycle after a mode set sets bit 7 (code 8). A gap of 2 is legal.
- R9: The burst length comes from mode_lo at the last mode set:
  - 000 gives 1
  - 001 gives 2
  - 010 gives 4
  - 011 gives 8
  - 111 gives full page
  - any other code gives 1

  A read or write with a10 high to an open bank at cycle t starts an auto-precharge burst. A read or write at cycles t+1 to t+BL-1 sets bit 8 (code 9), and the bank closes at cycle t+BL. A full-page burst stays in progress until a burst stop or a precharge of its bank, which closes the bank.
- R10: A precharge with a10 high closes all four banks regardless of ba.
- R11: A bank still open more than 10000 cycles after its activate sets bit 9 (code 10).
- R12: Flag bits are sticky. err_first holds the code of the first violation and stays put until cleared. When several violations occur in one cycle, the lowest code wins. A cycle with clr_i high leaves both outputs at zero and drops any violation in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of flags and first code |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable; commands ignored when low |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Auto-precharge / all-bank select |
| mode_lo | input | 3 | Low address bits, burst length code at mode set |
| err_flags | output | 10 | Sticky violation flags, one bit per rule |
| err_first | output | 4 | Code of the earliest violation, 0 when none |

## Verification
The properties assume that clr_i and the command lines are clean logic levels after reset. They also assume the all-bank precharge is never combined with an activate in the same cycle, which the command encoding already rules out. The bench drives every input on the falling edge so that each command lands on exactly one rising edge. Its random traffic uses only activate, read, write and precharge without auto-precharge, so an independent timestamp model can predict each flag. Mode sets, refreshes, auto-precharge bursts and the long open-time case are covered by directed sequences whose violating cycle is placed exactly.

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor #(
  parameter int T_CK_NS      = 10,
  parameter int T_RCD_NS     = 20,
  parameter int T_RP_NS      = 20,
  parameter int T_RAS_NS     = 50,
  parameter int T_RC_NS      = 70,
  parameter int T_RRD_NS     = 20,
  parameter int T_RAS_MAX_NS = 100000,
  parameter int MRD_CK       = 2,
  parameter int BA_W         = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic            cke,
  input  logic [BA_W-1:0] ba,
  input  logic            a10,
  input  logic [2:0]      mode_lo,
  output logic [9:0]      err_flags,
  output logic [3:0]      err_first
);
  localparam int NB        = 1 << BA_W;
  localparam int RCD_CK    = (T_RCD_NS + T_CK_NS - 1) / T_CK_NS;
  localparam int RP_CK     = (T_RP_NS + T_CK_NS - 1) / T_CK_NS;
  localparam int RAS_CK    = (T_RAS_NS + T_CK_NS - 1) / T_CK_NS;
  localparam int RC_CK     = (T_RC_NS + T_CK_NS - 1) / T_CK_NS;
  localparam int RRD_CK    = (T_RRD_NS + T_CK_NS - 1) / T_CK_NS;
  localparam int RASMAX_CK = (T_RAS_MAX_NS + T_CK_NS - 1) / T_CK_NS;
  localparam int AW        = $clog2(RASMAX_CK + 2);
  localparam int TW        = $clog2(RP_CK + RRD_CK + MRD_CK + 2);

  localparam logic [AW-1:0] A_SAT = AW'(RASMAX_CK + 1);
  localparam logic [AW-1:0] A_MAX = AW'(RASMAX_CK);
  localparam logic [AW-1:0] A_RCD = AW'(RCD_CK);
  localparam logic [AW-1:0] A_RAS = AW'(RAS_CK);
  localparam logic [AW-1:0] A_RC  = AW'(RC_CK);
  localparam logic [TW-1:0] T_SAT = '1;
  localparam logic [TW-1:0] T_RP  = TW'(RP_CK);
  localparam logic [TW-1:0] T_RRD = TW'(RRD_CK);
  localparam logic [TW-1:0] T_MRD = TW'(MRD_CK);

  logic [2:0] op;
  logic live, is_act, is_rd, is_wr, is_pre, is_ref, is_mrs, is_bst, is_cmd, is_rw;

  assign op     = {ras_n, cas_n, we_n};
  assign live   = !cs_n && cke;
  assign is_act = live && op == 3'b011;
  assign is_rd  = live && op == 3'b101;
  assign is_wr  = live && op == 3'b100;
  assign is_pre = live && op == 3'b010;
  assign is_ref = live && op == 3'b001;
  assign is_mrs = live && op == 3'b000;
  assign is_bst = live && op == 3'b110;
  assign is_cmd = live && op != 3'b111;
  assign is_rw  = is_rd || is_wr;

  logic [NB-1:0]   open_q;
  logic [AW-1:0]   act_cnt [NB];
  logic [TW-1:0]   pre_cnt [NB];
  logic [TW-1:0]   lact_cnt, mrs_cnt;
  logic [BA_W-1:0] lact_bank, ap_bank;
  logic [2:0]      mode_q;
  logic [3:0]      ap_left, bl_len;
  logic            ap_full, ap_live, ap_busy, ap_end, ap_go;
  logic [9:0]      viol;
  logic [3:0]      vcode;

  always_comb begin
    case (mode_q)
      3'd1:    bl_len = 4'd2;
      3'd2:    bl_len = 4'd4;
      3'd3:    bl_len = 4'd8;
      default: bl_len = 4'd1;
    endcase
  end

  assign ap_live = ap_full || ap_left != 4'd0;
  assign ap_busy = ap_full || ap_left > 4'd1;
  assign ap_end  = ap_live && ((!ap_full && ap_left == 4'd1) || is_bst ||
                               (is_pre && (a10 || ba == ap_bank)));
  assign ap_go   = is_rw && a10 && open_q[ba] && !ap_busy;

  always_comb begin
    viol = '0;
    for (int b = 0; b < NB; b++) begin
      if (open_q[b] && act_cnt[b] > A_MAX) viol[9] = 1'b1;
      if (is_pre && (a10 || ba == BA_W'(b)) && open_q[b] && act_cnt[b] < A_RAS) viol[2] = 1'b1;
    end
    if (is_rw) begin
      if (!open_q[ba]) viol[0] = 1'b1;
      else if (act_cnt[ba] < A_RCD) viol[1] = 1'b1;
      if (ap_busy) viol[8] = 1'b1;
    end
    if (is_act) begin
      if (pre_cnt[ba] < T_RP) viol[3] = 1'b1;
      if (lact_bank != ba && lact_cnt < T_RRD) viol[4] = 1'b1;
      if (act_cnt[ba] < A_RC) viol[5] = 1'b1;
    end
    if ((is_ref || is_mrs) && |open_q) viol[6] = 1'b1;
    if (is_cmd && mrs_cnt < T_MRD) viol[7] = 1'b1;
  end

  always_comb begin
    vcode = 4'd0;
    for (int i = 9; i >= 0; i--)
      if (viol[i]) vcode = 4'(i + 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= '0;
      for (int b = 0; b < NB; b++) begin
        act_cnt[b] <= A_SAT;
        pre_cnt[b] <= T_SAT;
      end
    end else begin
      for (int b = 0; b < NB; b++) begin
        pre_cnt[b] <= (pre_cnt[b] == T_SAT) ? T_SAT : pre_cnt[b] + 1'b1;
        if (is_act && ba == BA_W'(b)) begin
          open_q[b]  <= 1'b1;
          act_cnt[b] <= AW'(1);
        end else begin
          if (act_cnt[b] != A_SAT) act_cnt[b] <= act_cnt[b] + 1'b1;
          if (open_q[b] && ((is_pre && (a10 || ba == BA_W'(b))) ||
                            (ap_end && ap_bank == BA_W'(b)))) begin
            open_q[b]  <= 1'b0;
            pre_cnt[b] <= TW'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lact_cnt  <= T_SAT;
      mrs_cnt   <= T_SAT;
      lact_bank <= '0;
      mode_q    <= 3'd0;
      ap_left   <= 4'd0;
      ap_full   <= 1'b0;
      ap_bank   <= '0;
    end else begin
      lact_cnt <= (lact_cnt == T_SAT) ? T_SAT : lact_cnt + 1'b1;
      mrs_cnt  <= (mrs_cnt == T_SAT) ? T_SAT : mrs_cnt + 1'b1;
      if (is_act) begin
        lact_cnt  <= TW'(1);
        lact_bank <= ba;
      end
      if (is_mrs) begin
        mrs_cnt <= TW'(1);
        mode_q  <= mode_lo;
      end
      if (ap_end) begin
        ap_left <= 4'd0;
        ap_full <= 1'b0;
      end else if (ap_left != 4'd0) begin
        ap_left <= ap_left - 4'd1;
      end
      if (ap_go) begin
        ap_bank <= ba;
        ap_full <= mode_q == 3'd7;
        ap_left <= (mode_q == 3'd7) ? 4'd0 : bl_len;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flags <= '0;
      err_first <= 4'd0;
    end else if (clr_i) begin
      err_flags <= '0;
      err_first <= 4'd0;
    end else begin
      err_flags <= err_flags | viol;
      if (err_first == 4'd0) err_first <= vcode;
    end
  end

  a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (err_flags == 10'd0 && err_first == 4'd0));

  a_r12_first_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (err_first != 4'd0 && !clr_i) |=> $stable(err_first));

  a_r12_first_flag: assert property (@(posedge clk) disable iff (!rst_n)
    err_first != 4'd0 |-> (err_first <= 4'd10 &&
                           ((err_flags >> (err_first - 4'd1)) & 10'd1) != 10'd0));

  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !cke) |=> ((err_flags & ~$past(err_flags) & 10'h1FF) == 10'd0));

  a_r10_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && a10) |=> open_q == '0);

  a_r9_ap_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_end && !(is_act && ba == ap_bank) && !ap_go) |=> !open_q[$past(ap_bank)]);
endmodule

// File: tb/sim_sdram_cmd_monitor.sv
`timescale 1ns/1ps
module sim_sdram_cmd_monitor;
  localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100, C_PRE = 3'b010;
  localparam logic [2:0] C_REF = 3'b001, C_MRS = 3'b000, C_BST = 3'b110;

  logic clk = 1'b0, rst_n = 1'b0, clr_i = 1'b0, cs_n = 1'b1, cke = 1'b1;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [1:0] ba = 2'd0;
  logic [2:0] mode_lo = 3'd0;
  logic [9:0] err_flags;
  logic [3:0] err_first;
  int tests = 0, fails = 0, edge_n = 0;

  int t_act[4], t_pre[4], t_last, last_b;
  bit opn[4];
  logic [9:0] m_flags;
  int m_first;

  always #2 clk = ~clk;
  always @(posedge clk) edge_n <= edge_n + 1;

  sdram_cmd_monitor u0 (.clk(clk), .rst_n(rst_n), .clr_i(clr_i), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .cke(cke), .ba(ba), .a10(a10), .mode_lo(mode_lo),
    .err_flags(err_flags), .err_first(err_first));

  task automatic send(input logic [2:0] c, input int b, input logic ap, input logic [2:0] lo);
    @(negedge clk);
    cs_n = 1'b0; cke = 1'b1; clr_i = 1'b0;
    {ras_n, cas_n, we_n} = c; ba = b[1:0]; a10 = ap; mode_lo = lo;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cs_n = 1'b1; cke = 1'b1; clr_i = 1'b0;
    end
  endtask

  task automatic check(input string tag, input logic [9:0] ef, input int ec);
    @(negedge clk);
    cs_n = 1'b1; cke = 1'b1; clr_i = 1'b0;
    tests++;
    if (err_flags !== ef || err_first !== 4'(ec)) begin
      fails++;
      $display("FAIL %s: flags=%h first=%0d, expected flags=%h first=%0d",
               tag, err_flags, err_first, ef, ec);
    end
  endtask

  task automatic do_clr();
    @(negedge clk); clr_i = 1'b1; cs_n = 1'b1;
    @(negedge clk); clr_i = 1'b0;
  endtask

  task automatic cleanup();
    idle(12);
    send(C_PRE, 0, 1'b1, 3'd0);
    idle(3);
    do_clr();
  endtask

  function automatic int lowest(input logic [9:0] v);
    for (int i = 0; i < 10; i++) if (v[i]) return i + 1;
    return 0;
  endfunction

  task automatic model_cmd(input logic [2:0] c, input int b, input logic ap);
    int n;
    logic [9:0] v;
    n = edge_n + 1;
    v = '0;
    if (c == C_ACT) begin
      if (n - t_pre[b] < 2) v[3] = 1'b1;
      if (b != last_b && n - t_last < 2) v[4] = 1'b1;
      if (n - t_act[b] < 7) v[5] = 1'b1;
      opn[b] = 1'b1; t_act[b] = n; t_last = n; last_b = b;
    end else if (c == C_RD || c == C_WR) begin
      if (!opn[b]) v[0] = 1'b1;
      else if (n - t_act[b] < 2) v[1] = 1'b1;
    end else if (c == C_PRE) begin
      for (int k = 0; k < 4; k++)
        if ((ap || k == b) && opn[k]) begin
          if (n - t_act[k] < 5) v[2] = 1'b1;
          opn[k] = 1'b0; t_pre[k] = n;
        end
    end
    m_flags |= v;
    if (m_first == 0) m_first = lowest(v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R12 reset state", 10'h000, 0);

    // R1: deselect and clock-enable low hide an illegal read
    @(negedge clk); cs_n = 1'b1; {ras_n, cas_n, we_n} = C_RD; ba = 2'd1;
    @(negedge clk); cs_n = 1'b0; cke = 1'b0;
    check("R1 masked command", 10'h000, 0);

    send(C_RD, 1, 1'b0, 3'd0);
    check("R2 read closed bank", 10'h001, 1);
    do_clr();
    check("R12 clear", 10'h000, 0);

    send(C_ACT, 0, 1'b0, 3'd0);
    send(C_RD, 0, 1'b0, 3'd0);
    check("R3 read one cycle after activate", 10'h002, 2);
    send(C_WR, 0, 1'b0, 3'd0);
    check("R3 write after legal gap", 10'h002, 2);
    cleanup();

    send(C_ACT, 2, 1'b0, 3'd0);
    idle(2);
    send(C_PRE, 2, 1'b0, 3'd0);
    check("R4 precharge at gap 3", 10'h004, 3);
    do_clr();
    send(C_ACT, 3, 1'b0, 3'd0);
    idle(4);
    send(C_PRE, 3, 1'b0, 3'd0);
    send(C_ACT, 3, 1'b0, 3'd0);
    check("R5/R6 reopen 1 after precharge, 6 after activate", 10'h028, 4);
    cleanup();

    send(C_ACT, 0, 1'b0, 3'd0);
    send(C_ACT, 1, 1'b0, 3'd0);
    check("R6 activates to two banks back to back", 10'h010, 5);
    cleanup();

    send(C_ACT, 1, 1'b0, 3'd0);
    idle(3);
    send(C_REF, 0, 1'b0, 3'd0);
    check("R7 refresh with open bank", 10'h040, 7);
    cleanup();

    send(C_MRS, 0, 1'b0, 3'd2);
    send(C_ACT, 0, 1'b0, 3'd0);
    check("R8 command one cycle after mode set", 10'h080, 8);
    cleanup();
    send(C_MRS, 0, 1'b0, 3'd2);
    idle(1);
    send(C_ACT, 2, 1'b0, 3'd0);
    check("R8 command two cycles after mode set", 10'h000, 0);
    cleanup();

    // R9: burst length 4 with auto precharge on bank 0
    send(C_ACT, 0, 1'b0, 3'd0);
    idle(1);
    send(C_ACT, 1, 1'b0, 3'd0);
    idle(3);
    send(C_RD, 0, 1'b1, 3'd0);
    send(C_RD, 1, 1'b0, 3'd0);
    check("R9 read during auto-precharge burst", 10'h100, 9);
    do_clr();
    send(C_ACT, 0, 1'b0, 3'd0);
    check("R9 bank closes at end of burst (R5 gap 1)", 10'h008, 4);
    cleanup();

    send(C_MRS, 0, 1'b0, 3'd7);
    idle(2);
    send(C_ACT, 2, 1'b0, 3'd0);
    idle(3);
    send(C_WR, 2, 1'b1, 3'd0);
    idle(20);
    send(C_RD, 2, 1'b0, 3'd0);
    check("R9 full-page burst still in progress", 10'h100, 9);
    send(C_BST, 0, 1'b0, 3'd0);
    idle(1);
    send(C_RD, 2, 1'b0, 3'd0);
    check("R9 burst stop closes full-page bank", 10'h101, 9);
    cleanup();

    send(C_ACT, 0, 1'b0, 3'd0);
    idle(2);
    send(C_ACT, 3, 1'b0, 3'd0);
    idle(6);
    send(C_PRE, 1, 1'b1, 3'd0);
    check("R10 all-bank precharge legal", 10'h000, 0);
    send(C_RD, 0, 1'b0, 3'd0);
    check("R10 bank 0 closed", 10'h001, 1);
    do_clr();
    send(C_RD, 3, 1'b0, 3'd0);
    check("R10 bank 3 closed", 10'h001, 1);
    cleanup();

    send(C_ACT, 1, 1'b0, 3'd0);
    idle(9989);
    check("R11 open below limit", 10'h000, 0);
    idle(20);
    check("R11 open beyond limit", 10'h200, 10);
    cleanup();

    // R12: clear wins over a same-cycle violation
    @(negedge clk);
    clr_i = 1'b1; cs_n = 1'b0; {ras_n, cas_n, we_n} = C_RD; ba = 2'd2; a10 = 1'b0;
    check("R12 clear beats violation", 10'h000, 0);

    for (int k = 0; k < 4; k++) begin
      t_act[k] = -1000; t_pre[k] = -1000; opn[k] = 1'b0;
    end
    t_last = -1000; last_b = -1;
    for (int r = 0; r < 20; r++) begin
      do_clr();
      m_flags = '0; m_first = 0;
      for (int j = 0; j < 25; j++) begin
        int sel, b, gap;
        logic [2:0] c;
        logic ap;
        sel = $urandom_range(0, 3);
        b = $urandom_range(0, 3);
        ap = 1'b0;
        case (sel)
          0: c = C_ACT;
          1: c = C_RD;
          2: c = C_WR;
          default: begin c = C_PRE; ap = ($urandom_range(0, 3) == 0); end
        endcase
        send(c, b, ap, 3'd0);
        model_cmd(c, b, ap);
        gap = $urandom_range(0, 2);
        idle(gap);
      end
      check("R2/R3/R4/R5/R6 random traffic", m_flags, m_first);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule